// File: doc/BRIEF.md
# I2C Register Target Without Repeated START

This block is a serial-bus target that lets an external master read and write a bank of 256 byte-wide registers. It takes SCL and SDA as inputs that are already synchronised to the system clock. It finds START and STOP events by comparing each input with its value one clock earlier. It answers only to its own 7-bit device address, which is set by a parameter. It drives the bus through a single open-drain enable: when the enable is high the pad pulls SDA low, and when it is low the pad is released.

A write transaction carries the address byte with a low direction bit, then one subaddress byte that loads the register pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps on. A read transaction carries the address byte with a high direction bit and nothing else from the master. Data is returned starting at the pointer that the most recent write left behind. A master that wants to read a chosen register therefore first writes the subaddress alone, ends with STOP, and then starts a separate read.

A START that arrives while a transaction is open is not treated as the beginning of a new transaction. The target drops out and stays silent until a START arrives while it is idle.

Top module: `i2c_reg_target`

## Requirements
- R1: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A STOP at any point ends the transaction, releases SDA, and discards any byte that is only partly received. Register contents and the pointer are left as the last completed byte set them.
- R2: The first byte after START is shifted in MSB first. Its upper seven bits are the device address, and bit 0 is the direction (1 = read, 0 = write). When the address matches DEV_ADDR, the target pulls SDA low in the ninth (acknowledge) clock.
- R3: When the address does not match, the target never pulls SDA low. It ignores all further bits, including full bytes, until the next START.
- R4: In a write, the byte after the address byte is acknowledged and loaded into the 8-bit register pointer.
- R5: Each later write byte is acknowledged and stored in the register the pointer selects. The pointer then increases by one, wrapping from 255 to 0.
- R6: In a read, the target sends the register at the pointer, MSB first, and releases SDA in the acknowledge clock. The pointer increases by one, modulo 256, after every byte sent. An acknowledge from the master (SDA low) asks for the next byte.
- R7: A non-acknowledge from the master (SDA high) ends the read. The target then leaves SDA released for every later clock until a new START.
- R8: A START seen while a transaction is open drops the transaction. Bytes that follow are neither acknowledged nor stored until a START arrives while the target is idle. The pointer keeps any value already loaded.
- R9: The SDA enable changes only while SCL is low. It updates on the clock after SCL is seen to fall, and SDA is never driven high.
- R10: After reset, the SDA enable is low and every register and the pointer hold zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock, already synchronised to clk |
| sda_i | input | 1 | Bus data as seen on the wire, already synchronised |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
The hardest case to reach is a START that arrives while a transaction is open. A well-behaved master never sends one to this target, so the bench produces it on purpose. It completes the address and subaddress bytes of a write and then raises SDA while SCL is low. It then pulls SDA low again while SCL is high, which forms the second START. A full data byte follows, and it must be neither acknowledged nor stored. The bench also stops a data byte halfway through and runs reads that end with a non-acknowledge followed by extra idle clocks. The pointer and register state left by each of these cases is then read back through ordinary read transactions.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         PTR_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int NREG = 2 ** PTR_W;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WR, S_RD} st_t;

  st_t              st;
  logic             scl_q, sda_q;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       mem [NREG];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_ev = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  wire addr_hit = (shreg[7:1] == DEV_ADDR);
  wire [7:0] rd_byte = mem[ptr];
  wire [2:0] rd_idx  = 3'(4'd7 - bitcnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= (st == S_IDLE) ? S_ADDR : S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_i};
          bitcnt <= bitcnt + 4'd1;
        end else begin
          bitcnt <= '0;
          case (st)
            S_ADDR:  st <= !addr_hit ? S_IDLE : (shreg[0] ? S_RD : S_SUB);
            S_SUB:   st <= S_WR;
            S_RD: begin
              ptr <= ptr + 1'b1;
              if (sda_i) st <= S_IDLE;
            end
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_ADDR: sda_oe <= addr_hit;
            S_SUB: begin
              sda_oe <= 1'b1;
              ptr    <= shreg[PTR_W-1:0];
            end
            S_WR: begin
              sda_oe   <= 1'b1;
              mem[ptr] <= shreg;
              ptr      <= ptr + 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else begin
          sda_oe <= (st == S_RD) ? ~rd_byte[rd_idx] : 1'b0;
        end
      end
    end
  end

  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == S_IDLE) && !sda_oe);
  a_r8_restart_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && st != S_IDLE) |=> (st == S_IDLE));
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && st == S_IDLE) |=> (st == S_ADDR) && (bitcnt == 4'd0));
  a_r5_write_acks_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && bitcnt == 4'd8 && st == S_WR) |=> sda_oe && (ptr == $past(ptr) + 1'b1));
  a_r3_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && bitcnt == 4'd8 && st == S_ADDR && !addr_hit) |=> !sda_oe);
endmodule

// File: tb/test_i2c_reg_target.sv
`timescale 1ns/1ps
module test_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .PTR_W(8)) i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int tests = 0;
  int fails = 0;
  logic exp_oe = 1'b0;
  string cur_req = "R10";
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'h00;
  bit finished = 0;

  // per-clock comparison of the drive enable while SCL is high
  always @(negedge clk) begin
    #1;
    if (rst_n && scl_m && !finished) begin
      tests++;
      if (sda_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s: sda_oe=%0b expected %0b at %0t", cur_req, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b, input logic exp, output logic got);
    sda_m = b;
    repeat (4) @(negedge clk);
    exp_oe = exp;
    scl_m = 1'b1;
    repeat (2) @(negedge clk);
    got = sda_bus;
    repeat (2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    repeat (2) @(negedge clk);
    exp_oe = 1'b0;
    scl_m = 1'b1;
    repeat (3) @(negedge clk);
    sda_m = 1'b0;
    repeat (3) @(negedge clk);
    scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    repeat (3) @(negedge clk);
    exp_oe = 1'b0;
    scl_m = 1'b1;
    repeat (3) @(negedge clk);
    sda_m = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input string req, input logic [7:0] d, input logic ack);
    logic g;
    cur_req = req;
    for (int b = 7; b >= 0; b--) clock_bit(d[b], 1'b0, g);
    clock_bit(1'b1, ack, g);
    check(req, {7'd0, g}, {7'd0, ~ack});
  endtask

  task automatic do_write(input string req, input logic [6:0] a, input logic [7:0] sub,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input int n);
    logic hit;
    logic [7:0] dq [4];
    dq[0] = d0; dq[1] = d1; dq[2] = d2; dq[3] = d3;
    hit = (a == DEV);
    bus_start();
    send_byte(hit ? "R2" : "R3", {a, 1'b0}, hit);
    send_byte(hit ? "R4" : "R3", sub, hit);
    if (hit) ref_ptr = sub;
    for (int i = 0; i < n; i++) begin
      send_byte(hit ? req : "R3", dq[i], hit);
      if (hit) begin
        ref_mem[ref_ptr] = dq[i];
        ref_ptr = ref_ptr + 8'd1;
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input string req, input int n);
    logic g;
    logic [7:0] v;
    bus_start();
    send_byte("R2", {DEV, 1'b1}, 1'b1);
    for (int i = 0; i < n; i++) begin
      cur_req = req;
      for (int b = 7; b >= 0; b--) begin
        clock_bit(1'b1, ~ref_mem[ref_ptr][b], g);
        v[b] = g;
      end
      check(req, v, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
      clock_bit((i == n - 1), 1'b0, g);
    end
    cur_req = "R7";
    clock_bit(1'b1, 1'b0, g);
    clock_bit(1'b0, 1'b0, g);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic g;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {7'd0, sda_oe}, 8'h00);

    do_read("R10", 2);

    do_write("R5", DEV, 8'h10, 8'hA5, 8'h3C, 8'hF0, 8'h00, 3);
    do_write("R4", DEV, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    do_read("R6", 3);

    do_write("R5", DEV, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    check("R5", ref_ptr, 8'h02);
    do_read("R5", 2);
    do_write("R4", DEV, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    do_read("R5", 4);

    do_write("R3", DEV ^ 7'h01, 8'h10, 8'h99, 8'h98, 8'h00, 8'h00, 2);
    do_read("R3", 1);
    do_write("R4", DEV, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    do_read("R3", 2);

    // repeated START inside a write transaction
    bus_start();
    send_byte("R8", {DEV, 1'b0}, 1'b1);
    send_byte("R8", 8'h20, 1'b1);
    ref_ptr = 8'h20;
    cur_req = "R8";
    bus_start();
    send_byte("R8", 8'h77, 1'b0);
    send_byte("R8", 8'h66, 1'b0);
    bus_stop();
    do_read("R8", 1);

    // STOP in the middle of a data byte
    bus_start();
    send_byte("R1", {DEV, 1'b0}, 1'b1);
    send_byte("R1", 8'h30, 1'b1);
    send_byte("R1", 8'h5A, 1'b1);
    ref_mem[8'h30] = 8'h5A;
    ref_ptr = 8'h31;
    cur_req = "R1";
    clock_bit(1'b1, 1'b0, g);
    clock_bit(1'b1, 1'b0, g);
    clock_bit(1'b0, 1'b0, g);
    clock_bit(1'b1, 1'b0, g);
    bus_stop();
    do_read("R1", 1);
    do_write("R4", DEV, 8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    do_read("R1", 2);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule